// File: doc/BRIEF.md
# Auto-Increment Register Pointer Controller

This block keeps the register address pointer for a small register file of thirteen entries at addresses 0 to 12. It sits behind a serial-bus slave front end. The front end reports each START or repeated START addressed to the device and the direction of the transfer that follows. It also reports every byte received in a write and every byte sent in a read.

The first byte written after a START is a control byte. Its low four bits name a register. Bit 4 is reserved and must be zero. The top three bits select how the pointer moves after each data byte. The block checks the control byte, acknowledges it or refuses it, and then gives the address of each following data byte. After each such byte it moves the pointer according to the selected mode. It can hold the pointer still, sweep the whole file, or cycle inside one of three fixed windows.

All pins are plain strobes and levels, and the block never applies back-pressure. The acknowledge and the write enable are combinational and are valid in the same cycle as `wbyte_valid_i`, so the front end can drive the acknowledge bit from them directly. The pointer is visible on `reg_addr_o` at all times, and the front end uses it as the read address.

Top module: `aiptr_ctrl`

## Requirements
- R1: After reset the pointer is 0 and the mode is 000. A write byte strobed before the first START is refused (`ack_o`=0, `reg_we_o`=0).
- R2: The first write byte after a START in write direction (`xfer_read_i`=0) is a control byte. The block acknowledges it when bits [3:0] are at most 12, bit 4 is 0, and bits [7:5] are 000, 100, 101, 110 or 111. It then loads the pointer from bits [3:0] and the mode from bits [7:5], and raises no `reg_we_o`.
- R3: A control byte with index 13 to 15, with bit 4 set, or with mode 001, 010 or 011 is refused. Pointer and mode stay unchanged, and every further write byte up to the next START is refused and not written.
- R4: A write byte that follows an accepted control byte is acknowledged, with `reg_we_o`=1 and `reg_addr_o` equal to the pointer. The pointer then advances by the mode.
- R5: In mode 000 the pointer never advances.
- R6: In mode 100 the pointer counts up through 0..12, and 12 is followed by 0.
- R7: In mode 101 the pointer cycles through 2..5. From 5 or any higher address it goes to 2, and below 2 it counts up.
- R8: Mode 110 cycles through 6..7 and mode 111 cycles through 2..7. From the window top or above, each goes to its own window start, and below the window each counts up.
- R9: Each `rbyte_done_i` advances the pointer by the mode. A START in read direction loads nothing, so the pointer set by a write carries across a repeated START into a read.
- R10: A START strobe in the same cycle as a byte strobe does not lose the byte. The byte is handled under the old transaction, and the next write byte is then taken as a control byte.
- R11: `ai_mode_o` shows the mode last loaded by an accepted control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start_i | input | 1 | One-cycle strobe: START or repeated START addressed to the device |
| xfer_read_i | input | 1 | Direction qualifying `xfer_start_i` (1 = read) |
| wbyte_valid_i | input | 1 | One-cycle strobe: a byte was received in a write |
| wbyte_i | input | 8 | Received byte |
| rbyte_done_i | input | 1 | One-cycle strobe: a byte was sent in a read |
| ack_o | output | 1 | Acknowledge for the byte strobed this cycle |
| reg_we_o | output | 1 | Register file write enable for the byte strobed this cycle |
| reg_addr_o | output | 4 | Current pointer, used as the register address |
| ai_mode_o | output | 3 | Loaded auto-increment mode, for mirroring into the mode register |

## Verification
The collision of interest is a read-byte completion and a new START arriving in the same cycle. One event moves the pointer and the other re-arms control-byte capture. The bench raises `rbyte_done_i` and `xfer_start_i` together with the pointer inside the brightness window. It then checks that the pointer moved exactly one step. It also checks that the next write byte is acknowledged as a control byte with no write enable and that it reloads both pointer and mode.

// File: rtl/aiptr_pkg.sv
package aiptr_pkg;
  localparam int IDX_W  = 4;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    AI_HOLD   = 3'b000,
    AI_ALL    = 3'b100,
    AI_BRT    = 3'b101,
    AI_GRP    = 3'b110,
    AI_BRTGRP = 3'b111
  } ai_mode_e;
endpackage

// File: rtl/aiptr_decode.sv
module aiptr_decode
  import aiptr_pkg::*;
#(
  parameter int NUM_REGS = 13
) (
  input  logic [7:0]       ctrl_i,
  output logic             ok_o,
  output logic [IDX_W-1:0] idx_o,
  output ai_mode_e         mode_o
);
  logic [MODE_W-1:0] raw_mode;
  logic              idx_ok;
  logic              mode_ok;

  assign raw_mode = ctrl_i[7:5];
  assign idx_o    = ctrl_i[IDX_W-1:0];

  always_comb begin
    idx_ok = int'(idx_o) < NUM_REGS;
    case (raw_mode)
      3'b000, 3'b100, 3'b101, 3'b110, 3'b111: mode_ok = 1'b1;
      default:                                mode_ok = 1'b0;
    endcase
    mode_o = ai_mode_e'(raw_mode);
    ok_o   = idx_ok && !ctrl_i[4] && mode_ok;
  end
endmodule

// File: rtl/aiptr_step.sv
module aiptr_step
  import aiptr_pkg::*;
#(
  parameter int NUM_REGS = 13,
  parameter int BRT_LO   = 2,
  parameter int BRT_HI   = 5,
  parameter int GRP_LO   = 6,
  parameter int GRP_HI   = 7
) (
  input  logic [IDX_W-1:0] ptr_i,
  input  ai_mode_e         mode_i,
  output logic [IDX_W-1:0] nxt_o
);
  localparam int NWIN = 4;

  logic [NWIN-1:0][IDX_W-1:0] cand;

  // window 0: whole file, 1: brightness, 2: group, 3: brightness + group
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam int LO = (w == 0) ? 0 : (w == 2) ? GRP_LO : BRT_LO;
    localparam int HI = (w == 0) ? NUM_REGS - 1 : (w == 1) ? BRT_HI : GRP_HI;
    assign cand[w] = (int'(ptr_i) >= HI) ? IDX_W'(LO) : ptr_i + 1'b1;
  end

  always_comb begin
    case (mode_i)
      AI_ALL:    nxt_o = cand[0];
      AI_BRT:    nxt_o = cand[1];
      AI_GRP:    nxt_o = cand[2];
      AI_BRTGRP: nxt_o = cand[3];
      default:   nxt_o = ptr_i;
    endcase
  end
endmodule

// File: rtl/aiptr_ctrl.sv
module aiptr_ctrl
  import aiptr_pkg::*;
#(
  parameter int NUM_REGS = 13,
  parameter int BRT_LO   = 2,
  parameter int BRT_HI   = 5,
  parameter int GRP_LO   = 6,
  parameter int GRP_HI   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start_i,
  input  logic              xfer_read_i,
  input  logic              wbyte_valid_i,
  input  logic [7:0]        wbyte_i,
  input  logic              rbyte_done_i,
  output logic              ack_o,
  output logic              reg_we_o,
  output logic [IDX_W-1:0]  reg_addr_o,
  output logic [MODE_W-1:0] ai_mode_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_nxt;
  logic [IDX_W-1:0] ctl_idx;
  ai_mode_e         mode_q;
  ai_mode_e         ctl_mode;
  logic             ctl_ok;
  logic             ctl_pend_q;
  logic             refuse_q;
  logic             is_ctl;
  logic             is_data;
  logic             advance;

  aiptr_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .ctrl_i (wbyte_i),
    .ok_o   (ctl_ok),
    .idx_o  (ctl_idx),
    .mode_o (ctl_mode)
  );

  aiptr_step #(
    .NUM_REGS(NUM_REGS), .BRT_LO(BRT_LO), .BRT_HI(BRT_HI),
    .GRP_LO(GRP_LO), .GRP_HI(GRP_HI)
  ) u_step (
    .ptr_i  (ptr_q),
    .mode_i (mode_q),
    .nxt_o  (ptr_nxt)
  );

  assign is_ctl     = wbyte_valid_i && ctl_pend_q;
  assign is_data    = wbyte_valid_i && !ctl_pend_q && !refuse_q;
  assign advance    = is_data || rbyte_done_i;
  assign ack_o      = is_ctl ? ctl_ok : is_data;
  assign reg_we_o   = is_data;
  assign reg_addr_o = ptr_q;
  assign ai_mode_o  = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      mode_q     <= AI_HOLD;
      ctl_pend_q <= 1'b0;
      refuse_q   <= 1'b1;
    end else begin
      if (is_ctl) begin
        if (ctl_ok) begin
          ptr_q  <= ctl_idx;
          mode_q <= ctl_mode;
        end
        ctl_pend_q <= 1'b0;
        refuse_q   <= !ctl_ok;
      end else if (advance) begin
        ptr_q <= ptr_nxt;
      end
      // a new START re-arms capture after the byte of this cycle is handled
      if (xfer_start_i) begin
        ctl_pend_q <= !xfer_read_i;
        refuse_q   <= xfer_read_i;
      end
    end
  end

  // R2
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < NUM_REGS);

  // R4
  we_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> ack_o);

  // R3
  nack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wbyte_valid_i && ctl_pend_q && !ack_o) |=> ($stable(ptr_q) && $stable(mode_q)));

  // R5
  hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_o && mode_q == AI_HOLD) |=> $stable(ptr_q));

  // R7
  brt_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_o && mode_q == AI_BRT && int'(ptr_q) >= BRT_LO && int'(ptr_q) <= BRT_HI)
      |=> (int'(ptr_q) >= BRT_LO && int'(ptr_q) <= BRT_HI));
endmodule

// File: tb/sim_aiptr_ctrl.sv
module sim_aiptr_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xfer_start_i = 1'b0;
  logic       xfer_read_i = 1'b0;
  logic       wbyte_valid_i = 1'b0;
  logic [7:0] wbyte_i = 8'h00;
  logic       rbyte_done_i = 1'b0;
  logic       ack_o;
  logic       reg_we_o;
  logic [3:0] reg_addr_o;
  logic [2:0] ai_mode_o;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  aiptr_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .xfer_start_i(xfer_start_i), .xfer_read_i(xfer_read_i),
    .wbyte_valid_i(wbyte_valid_i), .wbyte_i(wbyte_i), .rbyte_done_i(rbyte_done_i),
    .ack_o(ack_o), .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o), .ai_mode_o(ai_mode_o)
  );

  typedef struct packed {
    logic [7:0] ctrl;
    logic       ack;
    logic [3:0] nbytes;
    logic [3:0] end_ptr;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{8'h80, 1'b1, 4'd3, 4'd3},
    '{8'h8B, 1'b1, 4'd3, 4'd1},
    '{8'hA4, 1'b1, 4'd4, 4'd4},
    '{8'hC7, 1'b1, 4'd3, 4'd6},
    '{8'hE6, 1'b1, 4'd3, 4'd3},
    '{8'h03, 1'b1, 4'd3, 4'd3},
    '{8'h8D, 1'b0, 4'd0, 4'd3},
    '{8'h90, 1'b0, 4'd0, 4'd3},
    '{8'h25, 1'b0, 4'd0, 4'd3},
    '{8'hA0, 1'b1, 4'd7, 4'd3},
    '{8'hC9, 1'b1, 4'd2, 4'd7},
    '{8'h8C, 1'b1, 4'd1, 4'd0}
  };

  // pointer step per R5..R8
  function automatic int model_next(int p, int m);
    int lo, hi;
    case (m)
      4: begin lo = 0; hi = 12; end
      5: begin lo = 2; hi = 5;  end
      6: begin lo = 6; hi = 7;  end
      7: begin lo = 2; hi = 7;  end
      default: return p;
    endcase
    return (p >= hi) ? lo : p + 1;
  endfunction

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_xfer(bit rd);
    @(negedge clk);
    xfer_start_i = 1'b1;
    xfer_read_i  = rd;
    @(negedge clk);
    xfer_start_i = 1'b0;
    xfer_read_i  = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack, output bit we, output int addr);
    @(negedge clk);
    wbyte_valid_i = 1'b1;
    wbyte_i       = b;
    #2;
    ack  = ack_o;
    we   = reg_we_o;
    addr = int'(reg_addr_o);
    @(negedge clk);
    wbyte_valid_i = 1'b0;
  endtask

  task automatic read_byte();
    @(negedge clk);
    rbyte_done_i = 1'b1;
    @(negedge clk);
    rbyte_done_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    bit ack, we;
    int addr, p, m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and refusal before any START
    check("R1 ptr", int'(reg_addr_o), 0);
    check("R1 mode", int'(ai_mode_o), 0);
    send_byte(8'h55, ack, we, addr);
    check("R1 ack", int'(ack), 0);
    check("R1 we", int'(we), 0);

    // vector table: R2..R8, R11
    for (int i = 0; i < NVEC; i++) begin
      start_xfer(1'b0);
      send_byte(VEC[i].ctrl, ack, we, addr);
      check(VEC[i].ack ? "R2 ctl ack" : "R3 ctl nack", int'(ack), int'(VEC[i].ack));
      check("R2 ctl no we", int'(we), 0);
      if (VEC[i].ack) begin
        check("R11 mode", int'(ai_mode_o), int'(VEC[i].ctrl[7:5]));
        p = int'(VEC[i].ctrl[3:0]);
        m = int'(VEC[i].ctrl[7:5]);
        for (int k = 0; k < int'(VEC[i].nbytes); k++) begin
          send_byte(8'(k), ack, we, addr);
          check("R4 data we", int'(we), 1);
          check("R4 R6 R7 R8 addr", addr, p);
          p = model_next(p, m);
        end
      end
      @(negedge clk);
      check("R5 R6 R7 R8 end ptr", int'(reg_addr_o), int'(VEC[i].end_ptr));
    end

    // R3 refused control locks the rest of the transaction
    start_xfer(1'b0);
    send_byte(8'h8E, ack, we, addr);
    check("R3 reserved idx", int'(ack), 0);
    send_byte(8'h11, ack, we, addr);
    check("R3 locked ack", int'(ack), 0);
    check("R3 locked we", int'(we), 0);
    check("R3 ptr kept", int'(reg_addr_o), 0);

    // R9 write control, repeated START to read, pointer steps per read
    start_xfer(1'b0);
    send_byte(8'hA4, ack, we, addr);
    start_xfer(1'b1);
    check("R9 kept across restart", int'(reg_addr_o), 4);
    check("R9 mode kept", int'(ai_mode_o), 5);
    send_byte(8'h77, ack, we, addr);
    check("R9 no write in read", int'(we), 0);
    read_byte();
    check("R9 read step", int'(reg_addr_o), 5);
    read_byte();
    check("R9 read wrap", int'(reg_addr_o), 2);
    read_byte();
    check("R9 read step2", int'(reg_addr_o), 3);

    // R10 read completion and START in the same cycle
    @(negedge clk);
    rbyte_done_i = 1'b1;
    xfer_start_i = 1'b1;
    xfer_read_i  = 1'b0;
    @(negedge clk);
    rbyte_done_i = 1'b0;
    xfer_start_i = 1'b0;
    check("R10 byte kept", int'(reg_addr_o), 4);
    send_byte(8'h81, ack, we, addr);
    check("R10 next is ctl ack", int'(ack), 1);
    check("R10 next is ctl no we", int'(we), 0);
    @(negedge clk);
    check("R10 ctl loaded ptr", int'(reg_addr_o), 1);
    check("R10 ctl loaded mode", int'(ai_mode_o), 4);

    finish_run();
  end
endmodule